// File: doc/BRIEF.md
# Ones' Complement Adder-Subtractor

This block adds or subtracts two signed integers held in ones' complement form. It has no clock, and its outputs settle from its inputs within the same cycle. A mode input selects the operation. In subtract mode the second operand is negated by inverting each of its bits. The two operands then pass through a ripple-carry adder. Any carry that leaves the most significant bit is fed back into bit 0 by a second incrementing pass. Ones' complement arithmetic needs this end-around carry to give the right answer.

The width is a parameter and defaults to 8 bits. The encoding has two zeros: all zeros is positive zero and all ones is negative zero. The block keeps negative zero as a legal result and does not rewrite it. An overflow output is raised when the true result cannot be represented in the chosen width.

Top module: `oc_addsub`

## Requirements
- R1: With `sub` = 0, the decoded value of `result` equals the decoded value of `a` plus the decoded value of `b` whenever that sum lies in the range −(2^(N−1)−1) to +(2^(N−1)−1). A word with bit N−1 set decodes to minus the value of its bitwise complement. Positive zero and negative zero count as equal.
- R2: With `sub` = 1, `b` is negated by bitwise complement, and the decoded `result` equals decoded `a` minus decoded `b` whenever that difference is in range.
- R3: A carry out of bit N−1 of the first addition is added back into bit 0. For N = 4: 0100 + 1100 gives 0001, 1011 + 1100 gives 1000, and 1011 + 0011 gives 1110.
- R4: `ovf` is 1 exactly when the true signed result falls outside ±(2^(N−1)−1). This is the case when `a` and the effective second operand have equal sign bits and bit N−1 of `result` differs from them. `ovf` is never 1 when those two sign bits differ.
- R5: Adding a word to its own bitwise complement, including any subtraction of a word from itself, yields all ones (negative zero) with `ovf` = 0. Negative zero is never rewritten as positive zero.
- R6: The end-around re-addition never produces a further carry out of bit N−1, so one re-addition is always enough.
- R7: The block is purely combinational: `result` and `ovf` reflect the present inputs with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | N | First operand, ones' complement |
| b | input | N | Second operand, ones' complement |
| sub | input | 1 | 0 adds, 1 subtracts `b` from `a` |
| result | output | N | Ones' complement sum or difference |
| ovf | output | 1 | Signed result out of range |

## Verification
The end-around carry and overflow detection can both act on the same operand pair. In the 4-bit case, 1000 + 1110 (−7 plus −1) carries out of the top bit and also leaves the representable range. Adding −0 to −7 carries out as well but stays in range. The exhaustive 4-bit sweep over both modes covers every such pair and judges the flag against the bench's integer sum. The same sweep checks that the wrapped value decodes correctly whenever the flag is clear. The negative-zero cases, where a carry-free add lands exactly on all ones, are checked bit for bit.

// File: rtl/oc_arith_pkg.sv
package oc_arith_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic s;
        logic c;
    } bit_sum_t;

    function automatic bit_sum_t full_add(input logic x, input logic y, input logic ci);
        bit_sum_t r;
        r.s = x ^ y ^ ci;
        r.c = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/oc_operand_cond.sv
module oc_operand_cond
    import oc_arith_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] b_in,
    input  op_mode_e     mode,
    output logic [W-1:0] b_eff
);
    always_comb begin
        b_eff = (mode == OP_SUB) ? ~b_in : b_in;
    end
endmodule

// File: rtl/oc_ripple_chain.sv
module oc_ripple_chain
    import oc_arith_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_stage
        bit_sum_t r;
        assign r        = full_add(x[i], y[i], c[i]);
        assign s[i]     = r.s;
        assign c[i+1]   = r.c;
    end

    assign cout = c[W];
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub
    import oc_arith_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sub,
    output logic [N-1:0] result,
    output logic         ovf
);
    localparam int MSB = N - 1;

    op_mode_e     mode;
    logic [N-1:0] b_eff;
    logic [N-1:0] raw_sum;
    logic         raw_carry;
    logic         wrap_carry;

    assign mode = op_mode_e'(sub);

    oc_operand_cond #(.W(N)) u_cond (
        .b_in  (b),
        .mode  (mode),
        .b_eff (b_eff)
    );

    oc_ripple_chain #(.W(N)) u_main (
        .x    (a),
        .y    (b_eff),
        .cin  (1'b0),
        .s    (raw_sum),
        .cout (raw_carry)
    );

    // End-around pass: add the main carry back into bit 0
    oc_ripple_chain #(.W(N)) u_wrap (
        .x    (raw_sum),
        .y    ('0),
        .cin  (raw_carry),
        .s    (result),
        .cout (wrap_carry)
    );

    assign ovf = (a[MSB] == b_eff[MSB]) && (result[MSB] != a[MSB]);

    always_comb begin
        a_r6_single_wrap: assert (!wrap_carry)
            else $error("R6: second carry out of end-around pass");
        a_r3_no_wrap_passthru: assert (raw_carry || result == raw_sum)
            else $error("R3: result changed without a carry to wrap");
        a_r4_mixed_sign_safe: assert ((a[MSB] == b_eff[MSB]) || !ovf)
            else $error("R4: overflow with opposite-sign operands");
        a_r5_negzero_kept: assert (((a ^ b_eff) != '1) || (result == '1 && !ovf))
            else $error("R5: complement pair did not give negative zero");
    end
endmodule

// File: tb/oc_addsub_tb.sv
module oc_addsub_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] a4, b4, r4;
    logic       s4, o4;
    logic [7:0] a8, b8, r8;
    logic       s8, o8;

    oc_addsub #(.N(4)) u_dut (.a(a4), .b(b4), .sub(s4), .result(r4), .ovf(o4));
    oc_addsub #(.N(8)) u_dut8 (.a(a8), .b(b8), .sub(s8), .result(r8), .ovf(o8));

    function automatic int dec(input int v, input int w);
        int mask = (1 << w) - 1;
        if (((v >> (w - 1)) & 1) != 0) return -((~v) & mask);
        return v & mask;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Judge one 4- or 8-bit result against the integer model (R1, R2, R4)
    task automatic judge(input int w, input int av, input int bv, input bit sb,
                         input int rv, input bit ov);
        int lim = (1 << (w - 1)) - 1;
        int tru = dec(av, w) + (sb ? -dec(bv, w) : dec(bv, w));
        bit eov = (tru > lim) || (tru < -lim);
        chk(ov == eov, "R4 overflow flag", ov, eov);
        if (!eov)
            chk(dec(rv, w) == tru, sb ? "R2 difference" : "R1 sum", dec(rv, w), tru);
    endtask

    initial begin
        a4 = '0; b4 = '0; s4 = 1'b0;
        a8 = '0; b8 = '0; s8 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R7: zero inputs give positive zero, no overflow, no clocking needed
        #1;
        chk(r4 == 4'b0000 && !o4, "R7 idle output", int'(r4), 0);

        // R3 worked cases
        @(negedge clk); a4 = 4'b0100; b4 = 4'b1100; s4 = 0;
        @(posedge clk); #1; chk(r4 == 4'b0001, "R3 4+(-3)", int'(r4), 1);
        @(negedge clk); a4 = 4'b1011; b4 = 4'b1100;
        @(posedge clk); #1; chk(r4 == 4'b1000, "R3 (-4)+(-3)", int'(r4), 8);
        @(negedge clk); a4 = 4'b1011; b4 = 4'b0011;
        @(posedge clk); #1; chk(r4 == 4'b1110, "R3 (-4)+3", int'(r4), 14);

        // R4 with a wrap: -7 + -1 overflows; -7 + -0 does not
        @(negedge clk); a4 = 4'b1000; b4 = 4'b1110;
        @(posedge clk); #1; chk(o4 == 1'b1, "R4 wrap and overflow", o4, 1);
        @(negedge clk); a4 = 4'b1000; b4 = 4'b1111;
        @(posedge clk); #1;
        chk(r4 == 4'b1000 && !o4, "R4 wrap no overflow", int'(r4), 8);

        // R5: x - x and 0 - 0 give negative zero
        @(negedge clk); a4 = 4'b0000; b4 = 4'b0000; s4 = 1;
        @(posedge clk); #1; chk(r4 == 4'b1111 && !o4, "R5 0-0", int'(r4), 15);
        @(negedge clk); a4 = 4'b0101; b4 = 4'b0101; s4 = 1;
        @(posedge clk); #1; chk(r4 == 4'b1111 && !o4, "R5 5-5", int'(r4), 15);

        // Exhaustive 4-bit sweep, both modes (R1, R2, R4, R5, R6)
        for (int m = 0; m < 2; m++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++) begin
                    @(negedge clk);
                    a4 = 4'(x); b4 = 4'(y); s4 = m[0];
                    @(posedge clk); #1;
                    judge(4, x, y, m[0], int'(r4), o4);
                    if ((m == 1 && x == y) || (m == 0 && (x ^ y) == 15))
                        chk(r4 == 4'b1111, "R5 negative zero kept", int'(r4), 15);
                end

        // Random 8-bit sweep
        for (int k = 0; k < 20000; k++) begin
            int x = int'($urandom & 255);
            int y = int'($urandom & 255);
            bit m = 1'($urandom);
            @(negedge clk);
            a8 = 8'(x); b8 = 8'(y); s8 = m;
            @(posedge clk); #1;
            judge(8, x, y, m, int'(r8), o8);
        end

        // R6: 8-bit extremes that carry out of the top bit
        @(negedge clk); a8 = 8'hFF; b8 = 8'hFF; s8 = 0;
        @(posedge clk); #1; chk(r8 == 8'hFF && !o8, "R6 -0 + -0", int'(r8), 255);
        @(negedge clk); a8 = 8'h80; b8 = 8'h80; s8 = 0;
        @(posedge clk); #1; chk(o8 == 1'b1, "R6 -127 + -127 overflow", o8, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule